// File: doc/BRIEF.md
# Page-Size-Split Address Translation Buffer

This block caches virtual-to-physical address translations for four page sizes: 1 MB sections, 64 KB large pages, 4 KB small pages and 1 KB tiny pages. Each page size has its own direct-mapped store. A lookup presents a 32-bit virtual address, and all four stores are probed in the same cycle. One clock later the block returns a hit flag, the 32-bit physical address, the permission/domain field stored with the translation, and the page size that produced the hit.

A page table walker outside the block loads translations through a fill port. The fill's page-size code selects the one store that is written. A single flush input empties every store in one cycle. The walker and the permission policy are outside this block. The instruction side and the data side each use their own instance, so the two translate independently and at the same time.

Top module: `mpsTlb`

## Requirements
- R1: While reset is active and after it is released, `rspValid` and `rspHit` are 0, and no lookup hits until a fill has been made.
- R2: `rspValid` is 1 exactly in the cycle after a cycle in which `lkValid` was 1. The response describes the `lkVa` of that earlier cycle.
- R3: On a hit in the store of page shift S, `rspPa` is the stored physical base bits [31:S] joined with `lkVa[S-1:0]`. `rspPerm` is the stored permission field. `rspSize` gives the page size, with 0 = 1 MB (S=20), 1 = 64 KB (S=16), 2 = 4 KB (S=12) and 3 = 1 KB (S=10).
- R4: Each store is indexed by the log2(entries) virtual-address bits starting at bit S, and the bits above those are compared as the tag. A lookup that matches an entry's index but not its tag misses. A fill to an index that is already occupied replaces the old entry.
- R5: A fill writes only the store chosen by `fillSize`. Entries in the other stores, and other indexes of the same store, are unchanged.
- R6: When several stores hit, the smallest page size is returned, in the priority 1 KB, then 4 KB, then 64 KB, then 1 MB.
- R7: `flushAll` invalidates every entry of every store in one cycle. A fill presented in the same cycle as a flush is discarded.
- R8: A lookup in the same cycle as a fill or a flush sees the contents held before that fill or flush.
- R9: `rspHit` is only ever 1 together with `rspValid`. On a miss, or when there is no response, `rspPa`, `rspPerm` and `rspSize` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request |
| lkVa | input | 32 | Virtual address to translate |
| rspValid | output | 1 | Response for the previous cycle's lookup |
| rspHit | output | 1 | A translation was found |
| rspPa | output | 32 | Translated physical address |
| rspPerm | output | PERM_W | Permission/domain field of the hit entry |
| rspSize | output | 2 | Page size of the hit (0=1MB,1=64KB,2=4KB,3=1KB) |
| fillValid | input | 1 | Write a translation |
| fillSize | input | 2 | Page size of the fill, which selects the target store |
| fillVa | input | 32 | Virtual address of the page being filled |
| fillPa | input | 32 | Physical base of the page (bits below the page size ignored) |
| fillPerm | input | PERM_W | Permission/domain field to store |
| flushAll | input | 1 | Invalidate every entry |

## Verification
The lookups cover addresses that hit only a 1 MB section, addresses that hit both a section and a smaller page (which shows the priority rule), and addresses that share an index but differ in tag (which separates index decoding from tag comparison). Physical bases are chosen so that each page size leaves a distinct page-offset width in the result. A wrong shift therefore shows up as a wrong address. An overwrite at an occupied index checks replacement and shows that the other stores are left alone. Directed steps combine a fill or a flush with a lookup in the same cycle, and a fill with a flush, to confirm the old-contents rule and the flush priority.

// File: rtl/mpsTlbPkg.sv
package mpsTlbPkg;
  localparam int VA_W = 32;
  localparam int PA_W = 32;
  localparam int NUM_SIZES = 4;

  typedef enum logic [1:0] {
    PG_SECTION = 2'd0,
    PG_LARGE   = 2'd1,
    PG_SMALL   = 2'd2,
    PG_TINY    = 2'd3
  } pgSize_e;

  // Address bit where the page offset ends, per page-size code.
  function automatic int pageShift(input int code);
    case (code)
      0:       return 20;
      1:       return 16;
      2:       return 12;
      default: return 10;
    endcase
  endfunction

  typedef struct packed {
    logic [NUM_SIZES-1:0] fillOne;  // one-hot store select for a fill
    logic                 flush;    // clear every valid bit
    logic                 probe;    // lookup this cycle
  } tlbStrb_t;
endpackage

// File: rtl/mpsTlbWay.sv
module mpsTlbWay #(
  parameter int ENTRIES = 4,
  parameter int SHIFT   = 20,
  parameter int PERM_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              wrEn,
  input  logic [31:0]       wrVa,
  input  logic [31:0]       wrPa,
  input  logic [PERM_W-1:0] wrPerm,
  input  logic [31:0]       lkVa,
  output logic              hit,
  output logic [31:0]       pa,
  output logic [PERM_W-1:0] perm
);
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int TAG_W  = 32 - SHIFT - IDX_W;
  localparam int BASE_W = 32 - SHIFT;

  logic [ENTRIES-1:0] validQ;
  logic [TAG_W-1:0]   tagQ  [ENTRIES];
  logic [BASE_W-1:0]  baseQ [ENTRIES];
  logic [PERM_W-1:0]  permQ [ENTRIES];

  logic [IDX_W-1:0] lkIdx, wrIdx;
  logic [TAG_W-1:0] lkTag, wrTag;

  assign lkIdx = lkVa[SHIFT +: IDX_W];
  assign wrIdx = wrVa[SHIFT +: IDX_W];
  assign lkTag = lkVa[31 -: TAG_W];
  assign wrTag = wrVa[31 -: TAG_W];

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      validQ <= '0;
    end else if (wrEn) begin
      validQ[wrIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn && !flush) begin
      tagQ[wrIdx]  <= wrTag;
      baseQ[wrIdx] <= wrPa[31 -: BASE_W];
      permQ[wrIdx] <= wrPerm;
    end
  end

  always_comb begin
    hit  = validQ[lkIdx] && (tagQ[lkIdx] == lkTag);
    pa   = {baseQ[lkIdx], lkVa[SHIFT-1:0]};
    perm = permQ[lkIdx];
  end

  // R5: a fill leaves its own slot valid on the next cycle
  a_r5_fill_marks_slot: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !flush) |=> validQ[$past(wrIdx)]);

  // R4: the written slot now holds the fill's tag
  a_r4_fill_tag_stored: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !flush) |=> (tagQ[$past(wrIdx)] == $past(wrTag)));
endmodule

// File: rtl/mpsTlbPath.sv
module mpsTlbPath
  import mpsTlbPkg::*;
#(
  parameter int N_SEC   = 4,
  parameter int N_LARGE = 8,
  parameter int N_SMALL = 16,
  parameter int N_TINY  = 32,
  parameter int PERM_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlbStrb_t          strb,
  input  logic [31:0]       lkVa,
  input  logic [31:0]       fillVa,
  input  logic [31:0]       fillPa,
  input  logic [PERM_W-1:0] fillPerm,
  output logic              rspValid,
  output logic              rspHit,
  output logic [31:0]       rspPa,
  output logic [PERM_W-1:0] rspPerm,
  output logic [1:0]        rspSize
);
  logic [NUM_SIZES-1:0] wayHit;
  logic [31:0]          wayPa   [NUM_SIZES];
  logic [PERM_W-1:0]    wayPerm [NUM_SIZES];

  for (genvar g = 0; g < NUM_SIZES; g++) begin : gWay
    localparam int ENT = (g == 0) ? N_SEC : (g == 1) ? N_LARGE :
                         (g == 2) ? N_SMALL : N_TINY;
    localparam int SH  = pageShift(g);
    mpsTlbWay #(.ENTRIES(ENT), .SHIFT(SH), .PERM_W(PERM_W)) uWay (
      .clk    (clk),
      .rstN   (rstN),
      .flush  (strb.flush),
      .wrEn   (strb.fillOne[g]),
      .wrVa   (fillVa),
      .wrPa   (fillPa),
      .wrPerm (fillPerm),
      .lkVa   (lkVa),
      .hit    (wayHit[g]),
      .pa     (wayPa[g]),
      .perm   (wayPerm[g])
    );
  end

  // Smaller pages sit at higher codes; later iterations override.
  logic              selHit;
  logic [31:0]       selPa;
  logic [PERM_W-1:0] selPerm;
  logic [1:0]        selSize;

  always_comb begin
    selHit  = 1'b0;
    selPa   = '0;
    selPerm = '0;
    selSize = '0;
    for (int k = 0; k < NUM_SIZES; k++) begin
      if (wayHit[k]) begin
        selHit  = 1'b1;
        selPa   = wayPa[k];
        selPerm = wayPerm[k];
        selSize = 2'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspPa    <= '0;
      rspPerm  <= '0;
      rspSize  <= '0;
    end else begin
      rspValid <= strb.probe;
      rspHit   <= strb.probe && selHit;
      rspPa    <= (strb.probe && selHit) ? selPa   : '0;
      rspPerm  <= (strb.probe && selHit) ? selPerm : '0;
      rspSize  <= (strb.probe && selHit) ? selSize : '0;
    end
  end

  // R2: one-cycle response latency
  a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    strb.probe |=> rspValid);

  // R9: a hit is always a valid response
  a_r9_hit_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> rspValid);

  // R3: the 1 KB offset common to every page size passes through unchanged
  a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> (rspPa[9:0] == $past(lkVa[9:0])));

  // R7: a lookup in the cycle after a flush finds nothing
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush ##1 strb.probe |=> !rspHit);
endmodule

// File: rtl/mpsTlbCtrl.sv
module mpsTlbCtrl
  import mpsTlbPkg::*;
(
  input  logic     lkValid,
  input  logic     fillValid,
  input  logic [1:0] fillSize,
  input  logic     flushAll,
  output tlbStrb_t strb
);
  always_comb begin
    strb.probe   = lkValid;
    strb.flush   = flushAll;
    strb.fillOne = '0;
    if (fillValid && !flushAll) begin
      strb.fillOne[fillSize] = 1'b1;
    end
  end
endmodule

// File: rtl/mpsTlb.sv
module mpsTlb
  import mpsTlbPkg::*;
#(
  parameter int N_SEC   = 4,
  parameter int N_LARGE = 8,
  parameter int N_SMALL = 16,
  parameter int N_TINY  = 32,
  parameter int PERM_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [31:0]       lkVa,
  output logic              rspValid,
  output logic              rspHit,
  output logic [31:0]       rspPa,
  output logic [PERM_W-1:0] rspPerm,
  output logic [1:0]        rspSize,
  input  logic              fillValid,
  input  logic [1:0]        fillSize,
  input  logic [31:0]       fillVa,
  input  logic [31:0]       fillPa,
  input  logic [PERM_W-1:0] fillPerm,
  input  logic              flushAll
);
  tlbStrb_t strb;

  mpsTlbCtrl uCtrl (
    .lkValid   (lkValid),
    .fillValid (fillValid),
    .fillSize  (fillSize),
    .flushAll  (flushAll),
    .strb      (strb)
  );

  mpsTlbPath #(
    .N_SEC(N_SEC), .N_LARGE(N_LARGE), .N_SMALL(N_SMALL),
    .N_TINY(N_TINY), .PERM_W(PERM_W)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .lkVa     (lkVa),
    .fillVa   (fillVa),
    .fillPa   (fillPa),
    .fillPerm (fillPerm),
    .rspValid (rspValid),
    .rspHit   (rspHit),
    .rspPa    (rspPa),
    .rspPerm  (rspPerm),
    .rspSize  (rspSize)
  );
endmodule

// File: tb/tb_mpsTlb.sv
module tb_mpsTlb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkValid = 1'b0;
  logic [31:0] lkVa = '0;
  logic        rspValid, rspHit;
  logic [31:0] rspPa;
  logic [7:0]  rspPerm;
  logic [1:0]  rspSize;
  logic        fillValid = 1'b0;
  logic [1:0]  fillSize = '0;
  logic [31:0] fillVa = '0, fillPa = '0;
  logic [7:0]  fillPerm = '0;
  logic        flushAll = 1'b0;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  mpsTlb dut (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVa(lkVa),
    .rspValid(rspValid), .rspHit(rspHit), .rspPa(rspPa),
    .rspPerm(rspPerm), .rspSize(rspSize), .fillValid(fillValid),
    .fillSize(fillSize), .fillVa(fillVa), .fillPa(fillPa),
    .fillPerm(fillPerm), .flushAll(flushAll)
  );

  // op: 0 lookup, 1 fill, 2 flush
  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  sz;
    logic [31:0] va;
    logic [31:0] pa;
    logic [7:0]  perm;
    logic        expHit;
    logic [31:0] expPa;
    logic [7:0]  expPerm;
    logic [1:0]  expSize;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 32'h0010_0000, 32'h0, 8'h00, 1'b0, 32'h0,          8'h00, 2'd0}, // R1 empty
    '{2'd1, 2'd0, 32'h1230_0000, 32'h8000_0000, 8'h11, 1'b0, 32'h0, 8'h00, 2'd0},
    '{2'd0, 2'd0, 32'h1234_5678, 32'h0, 8'h00, 1'b1, 32'h8004_5678, 8'h11, 2'd0}, // R3 section
    '{2'd0, 2'd0, 32'h1274_5678, 32'h0, 8'h00, 1'b0, 32'h0,          8'h00, 2'd0}, // R4 tag miss
    '{2'd1, 2'd2, 32'h1234_5000, 32'h00AB_C000, 8'h22, 1'b0, 32'h0, 8'h00, 2'd0},
    '{2'd0, 2'd0, 32'h1234_5678, 32'h0, 8'h00, 1'b1, 32'h00AB_C678, 8'h22, 2'd2}, // R6 4K over 1M
    '{2'd0, 2'd0, 32'h1234_6678, 32'h0, 8'h00, 1'b1, 32'h8004_6678, 8'h11, 2'd0}, // R5 other slot
    '{2'd1, 2'd3, 32'h1234_5400, 32'h5555_5400, 8'h33, 1'b0, 32'h0, 8'h00, 2'd0},
    '{2'd0, 2'd0, 32'h1234_5678, 32'h0, 8'h00, 1'b1, 32'h5555_5678, 8'h33, 2'd3}, // R6 1K wins
    '{2'd1, 2'd1, 32'h1234_0000, 32'h7FFF_0000, 8'h44, 1'b0, 32'h0, 8'h00, 2'd0},
    '{2'd0, 2'd0, 32'h1234_F000, 32'h0, 8'h00, 1'b1, 32'h7FFF_F000, 8'h44, 2'd1}, // R3 64K
    '{2'd1, 2'd2, 32'h2234_5000, 32'h0100_0000, 8'h55, 1'b0, 32'h0, 8'h00, 2'd0},
    '{2'd0, 2'd0, 32'h1234_5A00, 32'h0, 8'h00, 1'b1, 32'h7FFF_5A00, 8'h44, 2'd1}, // R4 evicted
    '{2'd0, 2'd0, 32'h2234_5123, 32'h0, 8'h00, 1'b1, 32'h0100_0123, 8'h55, 2'd2}, // R4 new tag
    '{2'd2, 2'd0, 32'h0,         32'h0, 8'h00, 1'b0, 32'h0,          8'h00, 2'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkResp(input string req, input logic eHit, input logic [31:0] ePa,
                           input logic [7:0] ePerm, input logic [1:0] eSize);
    check({req, " valid"}, {31'd0, rspValid}, 32'd1);
    check({req, " hit"},   {31'd0, rspHit},   {31'd0, eHit});
    check({req, " pa"},    rspPa,             ePa);
    check({req, " perm"},  {24'd0, rspPerm},  {24'd0, ePerm});
    check({req, " size"},  {30'd0, rspSize},  {30'd0, eSize});
  endtask

  task automatic idleAll();
    lkValid = 1'b0; fillValid = 1'b0; flushAll = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] va);
    @(negedge clk);
    lkValid = 1'b1; lkVa = va;
    @(negedge clk);
    idleAll();
  endtask

  task automatic fill(input logic [1:0] sz, input logic [31:0] va,
                      input logic [31:0] pa, input logic [7:0] perm);
    fillValid = 1'b1; fillSize = sz; fillVa = va; fillPa = pa; fillPerm = perm;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset valid", {31'd0, rspValid}, 32'd0);
    check("R1 reset hit",   {31'd0, rspHit},   32'd0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      case (VECS[i].op)
        2'd0: begin lkValid = 1'b1; lkVa = VECS[i].va; end
        2'd1: fill(VECS[i].sz, VECS[i].va, VECS[i].pa, VECS[i].perm);
        default: flushAll = 1'b1;
      endcase
      @(negedge clk);
      idleAll();
      if (VECS[i].op == 2'd0)
        checkResp($sformatf("R3/R4/R5/R6 vec%0d", i), VECS[i].expHit,
                  VECS[i].expPa, VECS[i].expPerm, VECS[i].expSize);
    end

    // R7: everything gone after the table's final flush
    lookup(32'h1234_5678);
    checkResp("R7 after flush", 1'b0, 32'h0, 8'h00, 2'd0);

    // R2: no response without a request
    @(negedge clk);
    check("R2 idle valid", {31'd0, rspValid}, 32'd0);

    // R8: lookup in the same cycle as a fill sees the old contents
    @(negedge clk);
    fill(2'd3, 32'h0000_0400, 32'h0001_0000, 8'h66);
    lkValid = 1'b1; lkVa = 32'h0000_0400;
    @(negedge clk);
    idleAll();
    checkResp("R8 fill same cycle", 1'b0, 32'h0, 8'h00, 2'd0);
    lookup(32'h0000_0400);
    checkResp("R8 fill visible", 1'b1, 32'h0001_0000, 8'h66, 2'd3);

    // R8: lookup in the same cycle as a flush still hits
    @(negedge clk);
    flushAll = 1'b1; lkValid = 1'b1; lkVa = 32'h0000_0400;
    @(negedge clk);
    idleAll();
    checkResp("R8 flush same cycle", 1'b1, 32'h0001_0000, 8'h66, 2'd3);
    lookup(32'h0000_0400);
    checkResp("R7 flush took effect", 1'b0, 32'h0, 8'h00, 2'd0);

    // R7: a fill together with a flush is dropped
    @(negedge clk);
    fill(2'd0, 32'h4000_0000, 32'h9000_0000, 8'h77);
    flushAll = 1'b1;
    @(negedge clk);
    idleAll();
    lookup(32'h4000_0000);
    checkResp("R7 fill dropped", 1'b0, 32'h0, 8'h00, 2'd0);

    // R9: miss outputs are zero, hit only with valid
    @(negedge clk);
    check("R9 no hit without valid", {31'd0, rspHit}, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule